// File: doc/BRIEF.md
# Host Peripheral Address Window Decoder

This block decides, one host cycle at a time, whether an I/O or memory access belongs to a peripheral that sits behind a sideband link. When it does, the block claims the cycle. It checks three fixed legacy I/O decodes, a bank of programmable I/O windows and a bank of programmable memory windows. When none of these match, an optional subtractive fallback can still claim the cycle. The block reports a claim flag, the kind of decode that won, and an index. For a window the index is the window number. For a fixed decode it is the decode number. For the subtractive fallback it is the selected target.

Software programs the block through a small register port. One write strobe carries an 8-bit byte address and a 32-bit data word, and the read data is a combinational function of the address. All enables sit in one shared word, which software updates by read-modify-write. Every window stores its length minus one, so a window of one byte has a size field of zero. The decode result is registered: a cycle presented at clock edge k is answered on the outputs right after edge k.

Top module: `hpd_decoder`

## Requirements
- R1: After reset every register reads zero and no cycle is claimed.
- R2: Register layout:
  - The enable word is at address 0x00. Bits 2:0 are the fixed decodes, bits 8+i are I/O window i, and bits 16+j are memory window j.
  - The control word is at 0x04. Bit 2 is the subtractive enable and bits 4:3 are the subtractive target.
  - I/O window i is at 0x40+4i, with the base in bits 15:0 and the length minus one in bits 23:16.
  - The base of memory window j is at 0x80+4j.
  - The length minus one of memory window j is at 0xC0+4j, bits 15:0.
  - Unimplemented bits read zero.
  - A write to any address leaves every other register unchanged, so a read-modify-write of the enable word keeps all other enables.
- R3: Fixed decodes apply only to single-byte I/O cycles, and the I/O port is address bits 15:0. Each is reported as kind 1:
  - port 0x80, when enable bit 0 is set, gives index 0;
  - port 0x60 or 0x64, when enable bit 1 is set, gives index 1;
  - port 0x2E or 0x2F, when enable bit 2 is set, gives index 2.
- R4: An enabled I/O window matches an I/O cycle of any access size when base <= port <= base + size field. Both bounds are inclusive, and the result is reported as kind 2 with the window index.
- R5: An enabled memory window matches a memory cycle when base <= address <= base + size field, computed without wrap. It is reported as kind 2 with the window index.
- R6: A window whose enable bit is clear never matches.
- R7: When several windows of the same space match, the lowest index is reported.
- R8: Fixed decodes take priority over windows, and windows take priority over the subtractive fallback.
- R9: With the subtractive enable set, a valid cycle that no positive decode claims is claimed as kind 3, with the index equal to the target field. With the enable clear, such a cycle is not claimed (kind 0).
- R10: The result of a cycle appears on the outputs after the next rising clock edge. A clock without a valid cycle yields no claim.
- R11: I/O windows and fixed decodes never match memory cycles, and memory windows never match I/O cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| cyc_valid | input | 1 | A host cycle is presented this clock |
| cyc_is_mem | input | 1 | 1 for a memory cycle, 0 for an I/O cycle |
| cyc_single | input | 1 | The cycle is a single-byte access |
| cyc_addr | input | 32 | Cycle address (I/O uses bits 15:0) |
| claim | output | 1 | The previous clock's cycle is claimed |
| claim_kind | output | 2 | 0 none, 1 fixed, 2 window, 3 subtractive |
| claim_idx | output | IDXW | Winning decode, window or target index |

## Verification
The assertions assume three things about the inputs. Reset holds cyc_valid and reg_wr low. Register writes and host cycles may arrive in the same clock; when they do, the decode uses the register values from before the write. cyc_is_mem and cyc_single are meaningful only while cyc_valid is high. The stimulus drives every input at the falling edge, keeps every input low during reset, and deliberately overlaps windows with each other and with the fixed ports. It also places cycles one address below, at, and one above each window bound, and includes a memory window whose end passes the top of the 32-bit space.

// File: rtl/hpd_pkg.sv
package hpd_pkg;

    typedef enum logic [1:0] {
        HIT_NONE  = 2'd0,
        HIT_FIXED = 2'd1,
        HIT_WIN   = 2'd2,
        HIT_SUB   = 2'd3
    } hit_kind_e;

    // register group selected by address bits 7:6
    localparam logic [1:0] GRP_CTRL    = 2'd0;
    localparam logic [1:0] GRP_IO_WIN  = 2'd1;
    localparam logic [1:0] GRP_MEM_BAS = 2'd2;
    localparam logic [1:0] GRP_MEM_LEN = 2'd3;

    localparam logic [7:0] ADDR_ENABLES = 8'h00;
    localparam logic [7:0] ADDR_CONTROL = 8'h04;

    localparam int FIX_COUNT   = 3;
    localparam int IO_EN_LSB   = 8;
    localparam int MEM_EN_LSB  = 16;
    localparam int SUB_EN_BIT  = 2;
    localparam int SUB_TGT_LSB = 3;

    localparam logic [15:0] PORT_POST  = 16'h0080;
    localparam logic [15:0] PORT_KBD_A = 16'h0060;
    localparam logic [15:0] PORT_KBD_B = 16'h0064;
    localparam logic [15:0] PORT_CFG_A = 16'h002E;
    localparam logic [15:0] PORT_CFG_B = 16'h002F;

endpackage

// File: rtl/hpd_regfile.sv
module hpd_regfile
    import hpd_pkg::*;
#(
    parameter int NIO  = 4,
    parameter int NMEM = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr,
    input  logic [7:0]                addr,
    input  logic [31:0]               wdata,
    output logic [31:0]               rdata,
    output logic [FIX_COUNT-1:0]      fx_en,
    output logic [NIO-1:0]            io_en,
    output logic [NMEM-1:0]           mem_en,
    output logic                      sub_en,
    output logic [1:0]                sub_tgt,
    output logic [NIO-1:0][15:0]      io_base,
    output logic [NIO-1:0][7:0]       io_len_m1,
    output logic [NMEM-1:0][31:0]     mem_base,
    output logic [NMEM-1:0][15:0]     mem_len_m1
);

    typedef struct packed {
        logic [FIX_COUNT-1:0]  fx;
        logic [NIO-1:0]        ioen;
        logic [NMEM-1:0]       memen;
        logic                  sub;
        logic [1:0]            tgt;
        logic [NIO-1:0][15:0]  iob;
        logic [NIO-1:0][7:0]   iol;
        logic [NMEM-1:0][31:0] mb;
        logic [NMEM-1:0][15:0] ml;
    } rf_t;

    rf_t        rf_d, rf_q;
    logic [1:0] grp;
    logic [3:0] sel;

    assign grp = addr[7:6];
    assign sel = addr[5:2];

    always_comb begin
        rf_d = rf_q;
        if (wr) begin
            case (grp)
                GRP_CTRL: begin
                    if (sel == 4'd0) begin
                        rf_d.fx    = wdata[FIX_COUNT-1:0];
                        rf_d.ioen  = wdata[IO_EN_LSB +: NIO];
                        rf_d.memen = wdata[MEM_EN_LSB +: NMEM];
                    end else if (sel == 4'd1) begin
                        rf_d.sub = wdata[SUB_EN_BIT];
                        rf_d.tgt = wdata[SUB_TGT_LSB +: 2];
                    end
                end
                GRP_IO_WIN: begin
                    for (int i = 0; i < NIO; i++) begin
                        if (sel == 4'(i)) begin
                            rf_d.iob[i] = wdata[15:0];
                            rf_d.iol[i] = wdata[23:16];
                        end
                    end
                end
                GRP_MEM_BAS: begin
                    for (int j = 0; j < NMEM; j++) begin
                        if (sel == 4'(j)) rf_d.mb[j] = wdata;
                    end
                end
                default: begin
                    for (int j = 0; j < NMEM; j++) begin
                        if (sel == 4'(j)) rf_d.ml[j] = wdata[15:0];
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rf_q <= '0;
        else        rf_q <= rf_d;
    end

    always_comb begin
        rdata = '0;
        case (grp)
            GRP_CTRL: begin
                if (sel == 4'd0) begin
                    rdata[FIX_COUNT-1:0]       = rf_q.fx;
                    rdata[IO_EN_LSB +: NIO]    = rf_q.ioen;
                    rdata[MEM_EN_LSB +: NMEM]  = rf_q.memen;
                end else if (sel == 4'd1) begin
                    rdata[SUB_EN_BIT]          = rf_q.sub;
                    rdata[SUB_TGT_LSB +: 2]    = rf_q.tgt;
                end
            end
            GRP_IO_WIN: begin
                for (int i = 0; i < NIO; i++) begin
                    if (sel == 4'(i)) rdata = {8'h00, rf_q.iol[i], rf_q.iob[i]};
                end
            end
            GRP_MEM_BAS: begin
                for (int j = 0; j < NMEM; j++) begin
                    if (sel == 4'(j)) rdata = rf_q.mb[j];
                end
            end
            default: begin
                for (int j = 0; j < NMEM; j++) begin
                    if (sel == 4'(j)) rdata = {16'h0000, rf_q.ml[j]};
                end
            end
        endcase
    end

    assign fx_en      = rf_q.fx;
    assign io_en      = rf_q.ioen;
    assign mem_en     = rf_q.memen;
    assign sub_en     = rf_q.sub;
    assign sub_tgt    = rf_q.tgt;
    assign io_base    = rf_q.iob;
    assign io_len_m1  = rf_q.iol;
    assign mem_base   = rf_q.mb;
    assign mem_len_m1 = rf_q.ml;

endmodule

// File: rtl/hpd_win_match.sv
module hpd_win_match #(
    parameter int N  = 4,
    parameter int AW = 16,
    parameter int SW = 8
) (
    input  logic [N-1:0]         en,
    input  logic [N-1:0][AW-1:0] base,
    input  logic [N-1:0][SW-1:0] len_m1,
    input  logic [AW-1:0]        addr,
    output logic [N-1:0]         hit
);

    for (genvar g = 0; g < N; g++) begin : g_win
        logic [AW:0] last;
        // one extra bit so a window reaching past the top does not wrap
        assign last   = {1'b0, base[g]} + (AW+1)'(len_m1[g]);
        assign hit[g] = en[g] && (addr >= base[g]) && ({1'b0, addr} <= last);
    end

endmodule

// File: rtl/hpd_prio.sv
module hpd_prio #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);

    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end

endmodule

// File: rtl/hpd_decoder.sv
module hpd_decoder
    import hpd_pkg::*;
#(
    parameter int NIO  = 4,
    parameter int NMEM = 4,
    localparam int NMAX = (NIO > NMEM) ? NIO : NMEM,
    localparam int IDXW = (NMAX > 4) ? $clog2(NMAX) : 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic [7:0]      reg_addr,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    input  logic            cyc_valid,
    input  logic            cyc_is_mem,
    input  logic            cyc_single,
    input  logic [31:0]     cyc_addr,
    output logic            claim,
    output logic [1:0]      claim_kind,
    output logic [IDXW-1:0] claim_idx
);

    typedef struct packed {
        logic            claim;
        hit_kind_e       kind;
        logic [IDXW-1:0] idx;
    } res_t;

    logic [FIX_COUNT-1:0]  fx_en;
    logic [NIO-1:0]        io_en;
    logic [NMEM-1:0]       mem_en;
    logic                  sub_en;
    logic [1:0]            sub_tgt;
    logic [NIO-1:0][15:0]  io_base;
    logic [NIO-1:0][7:0]   io_len_m1;
    logic [NMEM-1:0][31:0] mem_base;
    logic [NMEM-1:0][15:0] mem_len_m1;

    hpd_regfile #(.NIO(NIO), .NMEM(NMEM)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (reg_wr),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .rdata      (reg_rdata),
        .fx_en      (fx_en),
        .io_en      (io_en),
        .mem_en     (mem_en),
        .sub_en     (sub_en),
        .sub_tgt    (sub_tgt),
        .io_base    (io_base),
        .io_len_m1  (io_len_m1),
        .mem_base   (mem_base),
        .mem_len_m1 (mem_len_m1)
    );

    logic                 io_cyc, mem_cyc;
    logic [15:0]          port;
    logic [FIX_COUNT-1:0] fix_hit;

    assign io_cyc  = cyc_valid & ~cyc_is_mem;
    assign mem_cyc = cyc_valid &  cyc_is_mem;
    assign port    = cyc_addr[15:0];

    assign fix_hit[0] = io_cyc & cyc_single & fx_en[0] & (port == PORT_POST);
    assign fix_hit[1] = io_cyc & cyc_single & fx_en[1] &
                        ((port == PORT_KBD_A) | (port == PORT_KBD_B));
    assign fix_hit[2] = io_cyc & cyc_single & fx_en[2] &
                        ((port == PORT_CFG_A) | (port == PORT_CFG_B));

    logic [NIO-1:0]  io_hit;
    logic [NMEM-1:0] mem_hit;

    hpd_win_match #(.N(NIO), .AW(16), .SW(8)) u_io_match (
        .en     (io_en & {NIO{io_cyc}}),
        .base   (io_base),
        .len_m1 (io_len_m1),
        .addr   (port),
        .hit    (io_hit)
    );

    hpd_win_match #(.N(NMEM), .AW(32), .SW(16)) u_mem_match (
        .en     (mem_en & {NMEM{mem_cyc}}),
        .base   (mem_base),
        .len_m1 (mem_len_m1),
        .addr   (cyc_addr),
        .hit    (mem_hit)
    );

    logic            io_any, mem_any;
    logic [IDXW-1:0] io_idx, mem_idx;

    hpd_prio #(.N(NIO), .IW(IDXW)) u_io_prio (
        .req (io_hit),
        .any (io_any),
        .idx (io_idx)
    );

    hpd_prio #(.N(NMEM), .IW(IDXW)) u_mem_prio (
        .req (mem_hit),
        .any (mem_any),
        .idx (mem_idx)
    );

    res_t res_d, res_q;

    always_comb begin
        res_d = '0;
        if (|fix_hit) begin
            res_d.claim = 1'b1;
            res_d.kind  = HIT_FIXED;
            res_d.idx   = fix_hit[0] ? IDXW'(0) : (fix_hit[1] ? IDXW'(1) : IDXW'(2));
        end else if (io_any) begin
            res_d.claim = 1'b1;
            res_d.kind  = HIT_WIN;
            res_d.idx   = io_idx;
        end else if (mem_any) begin
            res_d.claim = 1'b1;
            res_d.kind  = HIT_WIN;
            res_d.idx   = mem_idx;
        end else if (cyc_valid && sub_en) begin
            res_d.claim = 1'b1;
            res_d.kind  = HIT_SUB;
            res_d.idx   = IDXW'(sub_tgt);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign claim      = res_q.claim;
    assign claim_kind = res_q.kind;
    assign claim_idx  = res_q.idx;

endmodule

// File: rtl/hpd_decoder_chk.sv
module hpd_decoder_chk #(
    parameter int NIO  = 4,
    parameter int NMEM = 4,
    parameter int IDXW = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            reg_wr,
    input logic [7:0]      reg_addr,
    input logic            cyc_valid,
    input logic            cyc_is_mem,
    input logic            cyc_single,
    input logic            claim,
    input logic [1:0]      claim_kind,
    input logic [IDXW-1:0] claim_idx,
    input logic [2:0]      fx_en,
    input logic [NIO-1:0]  io_en,
    input logic [NMEM-1:0] mem_en,
    input logic            sub_en
);

    p_claim_after_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        claim |-> $past(cyc_valid));

    p_fixed_single_io_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (claim && claim_kind == 2'd1) |-> $past(!cyc_is_mem && cyc_single));

    p_io_win_enabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (claim && claim_kind == 2'd2 && !$past(cyc_is_mem))
            |-> (|($past(io_en) & (NIO'(1) << claim_idx))));

    p_mem_win_enabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (claim && claim_kind == 2'd2 && $past(cyc_is_mem))
            |-> (|($past(mem_en) & (NMEM'(1) << claim_idx))));

    p_sub_needs_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (claim && claim_kind == 2'd3) |-> $past(sub_en));

    p_enables_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr != 8'h00) |=> $stable({fx_en, io_en, mem_en}));

endmodule

bind hpd_decoder hpd_decoder_chk #(.NIO(NIO), .NMEM(NMEM), .IDXW(IDXW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .cyc_valid  (cyc_valid),
    .cyc_is_mem (cyc_is_mem),
    .cyc_single (cyc_single),
    .claim      (claim),
    .claim_kind (claim_kind),
    .claim_idx  (claim_idx),
    .fx_en      (fx_en),
    .io_en      (io_en),
    .mem_en     (mem_en),
    .sub_en     (sub_en)
);

// File: tb/hpd_decoder_bench.sv
module hpd_decoder_bench;

    localparam int NIO  = 4;
    localparam int NMEM = 4;
    localparam int IW   = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [7:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          cyc_valid = 1'b0;
    logic          cyc_is_mem = 1'b0;
    logic          cyc_single = 1'b0;
    logic [31:0]   cyc_addr = '0;
    logic          claim;
    logic [1:0]    claim_kind;
    logic [IW-1:0] claim_idx;

    always #4 clk = ~clk;

    hpd_decoder #(.NIO(NIO), .NMEM(NMEM)) u_hpd_decoder (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .cyc_valid  (cyc_valid),
        .cyc_is_mem (cyc_is_mem),
        .cyc_single (cyc_single),
        .cyc_addr   (cyc_addr),
        .claim      (claim),
        .claim_kind (claim_kind),
        .claim_idx  (claim_idx)
    );

    int    total = 0;
    int    bad = 0;
    bit    done = 0;
    string cur_req = "R1";

    // behavioural register image
    logic [31:0] m_en = 0, m_ctl = 0;
    logic [15:0] m_iob [NIO];
    logic [7:0]  m_iol [NIO];
    logic [31:0] m_mb  [NMEM];
    logic [15:0] m_ml  [NMEM];
    initial begin
        for (int i = 0; i < NIO; i++) begin m_iob[i] = 0; m_iol[i] = 0; end
        for (int j = 0; j < NMEM; j++) begin m_mb[j] = 0; m_ml[j] = 0; end
    end

    function automatic void model_write(logic [7:0] a, logic [31:0] d);
        int g = int'(a[7:6]);
        int s = int'(a[5:2]);
        if (g == 0 && s == 0) m_en = d & 32'h000F_0F07;
        else if (g == 0 && s == 1) m_ctl = d & 32'h0000_001C;
        else if (g == 1 && s < NIO) begin m_iob[s] = d[15:0]; m_iol[s] = d[23:16]; end
        else if (g == 2 && s < NMEM) m_mb[s] = d;
        else if (g == 3 && s < NMEM) m_ml[s] = d[15:0];
    endfunction

    function automatic logic [31:0] model_read(logic [7:0] a);
        int g = int'(a[7:6]);
        int s = int'(a[5:2]);
        if (g == 0 && s == 0) return m_en;
        if (g == 0 && s == 1) return m_ctl;
        if (g == 1 && s < NIO) return {8'h00, m_iol[s], m_iob[s]};
        if (g == 2 && s < NMEM) return m_mb[s];
        if (g == 3 && s < NMEM) return {16'h0, m_ml[s]};
        return 0;
    endfunction

    int e_claim = 0, e_kind = 0, e_idx = 0;

    task automatic predict();
        int p;
        longint ad;
        e_claim = 0; e_kind = 0; e_idx = 0;
        if (!cyc_valid) return;
        p  = int'(cyc_addr[15:0]);
        ad = longint'(cyc_addr);
        if (!cyc_is_mem && cyc_single) begin
            if (m_en[0] && p == 'h80) begin e_claim = 1; e_kind = 1; e_idx = 0; return; end
            if (m_en[1] && (p == 'h60 || p == 'h64)) begin e_claim = 1; e_kind = 1; e_idx = 1; return; end
            if (m_en[2] && (p == 'h2E || p == 'h2F)) begin e_claim = 1; e_kind = 1; e_idx = 2; return; end
        end
        if (!cyc_is_mem) begin
            for (int i = 0; i < NIO; i++)
                if (m_en[8+i] && p >= int'(m_iob[i]) && p <= int'(m_iob[i]) + int'(m_iol[i])) begin
                    e_claim = 1; e_kind = 2; e_idx = i; return;
                end
        end else begin
            for (int j = 0; j < NMEM; j++)
                if (m_en[16+j] && ad >= longint'(m_mb[j]) &&
                    ad <= longint'(m_mb[j]) + longint'(m_ml[j])) begin
                    e_claim = 1; e_kind = 2; e_idx = j; return;
                end
        end
        if (m_ctl[2]) begin e_claim = 1; e_kind = 3; e_idx = int'(m_ctl[4:3]); end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            e_claim = 0; e_kind = 0; e_idx = 0;
        end else begin
            predict();
            if (reg_wr) model_write(reg_addr, reg_wdata);
        end
    end

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            total++;
            if (int'(claim) != e_claim || int'(claim_kind) != e_kind || int'(claim_idx) != e_idx) begin
                bad++;
                $display("FAIL %s claim/kind/idx got %0d/%0d/%0d exp %0d/%0d/%0d at %0t",
                         cur_req, claim, claim_kind, claim_idx, e_claim, e_kind, e_idx, $time);
            end
        end
    end

    task automatic step(bit w, logic [7:0] wa, logic [31:0] wd,
                        bit v, bit m, bit s, logic [31:0] a);
        @(negedge clk);
        reg_wr = w; reg_addr = wa; reg_wdata = wd;
        cyc_valid = v; cyc_is_mem = m; cyc_single = s; cyc_addr = a;
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        step(1, a, d, 0, 0, 0, 0);
    endtask

    task automatic io(logic [15:0] p, bit s);
        step(0, 0, 0, 1, 0, s, {16'h0, p});
    endtask

    task automatic mem(logic [31:0] a);
        step(0, 0, 0, 1, 1, 0, a);
    endtask

    task automatic rd_check(logic [7:0] a, string tag);
        logic [31:0] ex;
        step(0, a, 0, 0, 0, 0, 0);
        #2;
        ex = model_read(a);
        total++;
        if (reg_rdata !== ex) begin
            bad++;
            $display("FAIL %s read 0x%02h got 0x%08h exp 0x%08h", tag, a, reg_rdata, ex);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            bad++;
            $display("FAIL watchdog expired in %s", cur_req);
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        logic [31:0] bases [8];
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of every register
        cur_req = "R1";
        rd_check(8'h00, "R1"); rd_check(8'h04, "R1");
        for (int i = 0; i < 4; i++) begin
            rd_check(8'(8'h40 + 4*i), "R1");
            rd_check(8'(8'h80 + 4*i), "R1");
            rd_check(8'(8'hC0 + 4*i), "R1");
        end
        io(16'h0080, 1); mem(32'hFED0_0000);

        // R2: field masks and read-modify-write of the enable word
        cur_req = "R2";
        wr(8'h00, 32'h0000_0100);
        rd_check(8'h00, "R2");
        v = model_read(8'h00) | 32'h0001_0000;
        wr(8'h00, v);
        rd_check(8'h00, "R2");
        wr(8'h04, 32'hFFFF_FFFF); rd_check(8'h04, "R2");
        wr(8'h4C, 32'hFFFF_FFFF); rd_check(8'h4C, "R2");
        wr(8'hC4, 32'hFFFF_FFFF); rd_check(8'hC4, "R2");
        rd_check(8'h00, "R2");
        wr(8'h08, 32'hFFFF_FFFF); rd_check(8'h08, "R2");
        wr(8'h04, 32'h0);

        // windows: overlapping I/O 0/1, I/O 2 on the fixed port, I/O 3 disabled
        wr(8'h40, 32'h000F_0300);
        wr(8'h44, 32'h0003_0308);
        wr(8'h48, 32'h0000_0080);
        wr(8'h4C, 32'h00FF_1000);
        wr(8'h80, 32'hFED0_0000); wr(8'hC0, 32'h0000_0FFF);
        wr(8'h84, 32'hFFFF_F000); wr(8'hC4, 32'h0000_FFFF);
        wr(8'h88, 32'h000C_0000); wr(8'hC8, 32'h0000_0000);
        wr(8'h8C, 32'h1000_0000); wr(8'hCC, 32'h0000_FFFF);
        wr(8'h00, 32'h0007_0707);
        rd_check(8'h00, "R2");

        cur_req = "R3";
        io(16'h0080, 1); io(16'h0060, 1); io(16'h0064, 1); io(16'h0061, 1);
        io(16'h002E, 1); io(16'h002F, 1); io(16'h0030, 1);
        cur_req = "R8";
        io(16'h0080, 0); io(16'h0060, 0);
        cur_req = "R4";
        io(16'h02FF, 0); io(16'h0300, 0); io(16'h030F, 0); io(16'h0310, 1);
        cur_req = "R7";
        io(16'h0308, 0); io(16'h030B, 1);
        cur_req = "R6";
        io(16'h1000, 0); io(16'h1080, 1); mem(32'h1000_0010);
        cur_req = "R5";
        mem(32'hFECF_FFFF); mem(32'hFED0_0000); mem(32'hFED0_0FFF); mem(32'hFED0_1000);
        mem(32'hFFFF_FFFF); mem(32'h000C_0000); mem(32'h000C_0001);
        cur_req = "R11";
        mem(32'h0000_0300); mem(32'h0000_0080); io(16'h0000, 0);
        step(0, 0, 0, 1, 0, 1, 32'hFED0_0080);

        // R9: subtractive fallback with target 2
        cur_req = "R9";
        wr(8'h04, 32'h0000_0014);
        io(16'h0310, 0); mem(32'h0000_0000); io(16'h0300, 0); io(16'h0080, 1);
        step(0, 0, 0, 0, 1, 1, 32'h0000_0000);
        v = model_read(8'h00) & ~32'h0000_0002;
        wr(8'h00, v);
        rd_check(8'h00, "R9");
        io(16'h0064, 1); io(16'h002F, 1);

        // R10: writes overlapping cycles, idle clocks
        cur_req = "R10";
        step(1, 8'h04, 32'h0000_0000, 1, 0, 0, 32'h0000_0500);
        io(16'h0500, 0);
        step(0, 0, 0, 0, 0, 1, 32'h0000_0080);

        // mixed stimulus near every boundary
        cur_req = "R8";
        wr(8'h04, 32'h0000_000C);
        bases[0] = 32'h0300; bases[1] = 32'h0080; bases[2] = 32'h0060; bases[3] = 32'h002E;
        bases[4] = 32'hFED0_0F80; bases[5] = 32'hFFFF_F000; bases[6] = 32'h000C_0000;
        bases[7] = 32'h1000;
        seed = 32'h1234_5678;
        for (int k = 0; k < 400; k++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            if (k == 200) begin wr(8'h00, 32'h000F_0F07); continue; end
            step(0, 0, 0, seed[20] | seed[21], seed[23], seed[24],
                 bases[seed[18:16]] + {28'h0, seed[11:8]} - 32'd8);
        end
        step(0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        done = 1;
        summary();
        $finish;
    end

endmodule